// File: doc/BRIEF.md
# Floating-Point Min/Max Selection Unit

This unit picks one of two IEEE-754 operands and passes it through bit for bit. It supports four selections: minimum, maximum, minimum by magnitude and maximum by magnitude. Each selection works in single or double precision. A 32-bit instruction word supplies the selection and the precision. When `valid_in` is high, the unit decodes that word, compares the operands with a quiet comparison and registers the chosen operand, an exception-flag vector and an illegal-encoding indication. All of these appear one cycle later, with `valid_out` high.

The magnitude forms compare the operands with their sign bits cleared. They return the chosen operand with its original sign. NaN inputs follow a fixed rule that favours the first operand. A NaN in operand 1 alone makes the comparison fail, so operand 2 is returned. A NaN in operand 2 always keeps operand 1. Only a signalling NaN raises the invalid-operation flag.

Top module: `fsel_unit`

## Requirements
- R1: The outputs are registered. `valid_out` equals `valid_in` of the previous cycle. `result`, `exc_flags` and `illegal` load only on a cycle with `valid_in` high and hold otherwise. After reset, every output is zero.
- R2: A word is legal only when bits [6:0] = 0x53, bits [11:7] = 0 (single) or 1 (double), and bits [16:12] = 0x18 (min), 0x19 (max), 0x1A (minmag) or 0x1B (maxmag). Bits [31:17] are ignored. Any other word sets `illegal` and forces `result` and `exc_flags` to zero.
- R3: Max returns operand 1 when operand 2 is NaN, or when operand 2 ≤ operand 1 by quiet comparison. Otherwise it returns operand 2. The result is always one of the operands, unchanged.
- R4: Min returns operand 1 when operand 2 is NaN, or when operand 1 < operand 2 by quiet comparison. Otherwise it returns operand 2.
- R5: Minmag and maxmag use the R4 and R3 rules on the operands with the sign bit forced to zero. The operand returned keeps its original sign bit.
- R6: If operand 1 is NaN and operand 2 is not, operand 2 is returned. If both are NaN, operand 1 is returned. This holds for all four selections.
- R7: `exc_flags` is 5 bits wide. Bit 4 is invalid-operation and is set when either operand is a signalling NaN. A signalling NaN has an all-ones exponent, a nonzero mantissa and a clear top mantissa bit. Quiet NaNs raise nothing. Bits [3:0] are always zero.
- R8: Single precision reads operand bits [31:0] only and ignores bits [63:32]. In single precision, `result[63:32]` is zero.
- R9: +0 and −0 compare equal. With two zeros, max and maxmag return operand 1, and min and minmag return operand 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_in | input | 1 | Operation strobe |
| instr | input | 32 | Instruction word selecting operation and precision |
| op_a | input | 64 | Operand 1 |
| op_b | input | 64 | Operand 2 |
| valid_out | output | 1 | Result valid, one cycle after `valid_in` |
| result | output | 64 | Selected operand |
| exc_flags | output | 5 | Exception flags, bit 4 invalid-operation |
| illegal | output | 1 | Instruction word matched no legal encoding |

## Verification
The assertions check these properties on every cycle:
- the one-cycle strobe timing, and that outputs hold between strobes;
- that an illegal word yields zero result and zero flags;
- that a legal result is one of the two operands, with the upper half zero in single precision;
- that the quiet order can never report both a < b and b ≤ a, and reports neither when a NaN is present.

Only the bench's sweeps can show which operand is correct. It runs every pair from a set of zeros, normals, subnormals, infinities and quiet and signalling NaNs of both signs, in both precisions and all four selections. This covers the NaN-position rule, the signed-zero tie-break, the magnitude ordering across signs and the invalid flag.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

  typedef enum logic [1:0] {
    SEL_MIN    = 2'd0,
    SEL_MAX    = 2'd1,
    SEL_MINMAG = 2'd2,
    SEL_MAXMAG = 2'd3
  } sel_op_e;

  typedef struct packed {
    logic    legal;
    logic    dbl;
    sel_op_e op;
  } sel_cmd_t;

  localparam int        MATCH_W     = 17;
  localparam logic [6:0] OPC_FP     = 7'h53;
  localparam logic [4:0] FMT_SINGLE = 5'd0;
  localparam logic [4:0] FMT_DOUBLE = 5'd1;
  localparam logic [2:0] FN_GROUP   = 3'b110;
  localparam int        FLAG_W      = 5;
  localparam int        FLAG_INV    = 4;

endpackage

// File: rtl/fsel_decode.sv
module fsel_decode
  import fsel_pkg::*;
(
  input  logic [MATCH_W-1:0] field,
  output sel_cmd_t           cmd
);

  logic [6:0] opc;
  logic [4:0] fmt;
  logic [4:0] fn;
  logic       opc_hit;
  logic       fmt_hit;
  logic       fn_hit;

  assign opc = field[6:0];
  assign fmt = field[11:7];
  assign fn  = field[16:12];

  assign opc_hit = (opc == OPC_FP);
  assign fmt_hit = (fmt == FMT_SINGLE) || (fmt == FMT_DOUBLE);
  assign fn_hit  = (fn[4:2] == FN_GROUP);

  always_comb begin
    cmd.legal = opc_hit && fmt_hit && fn_hit;
    cmd.dbl   = (fmt == FMT_DOUBLE);
    cmd.op    = sel_op_e'(fn[1:0]);
  end

endmodule

// File: rtl/fsel_order.sv
module fsel_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] x,
  input  logic [EXP_W+MAN_W:0] y,
  output logic                 lt_xy,
  output logic                 le_yx
);

  localparam int W = 1 + EXP_W + MAN_W;

  function automatic logic f_nan(input logic [W-1:0] v);
    return (&v[W-2:MAN_W]) && (|v[MAN_W-1:0]);
  endfunction

  function automatic logic f_lt(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [W-2:0] pm;
    logic [W-2:0] qm;
    pm = p[W-2:0];
    qm = q[W-2:0];
    if (f_nan(p) || f_nan(q)) return 1'b0;
    if (pm == '0 && qm == '0) return 1'b0;
    if (p[W-1] != q[W-1]) return p[W-1];
    if (!p[W-1]) return pm < qm;
    return pm > qm;
  endfunction

  function automatic logic f_le(input logic [W-1:0] p, input logic [W-1:0] q);
    if (f_nan(p) || f_nan(q)) return 1'b0;
    if (p == q) return 1'b1;
    if (p[W-2:0] == '0 && q[W-2:0] == '0) return 1'b1;
    return f_lt(p, q);
  endfunction

  assign lt_xy = f_lt(x, y);
  assign le_yx = f_le(y, x);

  always_comb begin
    AST_ORDER_EXCLUSIVE: assert (!(lt_xy && le_yx)); // R4
  end

endmodule

// File: rtl/fsel_lane.sv
module fsel_lane
  import fsel_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int OUT_W = 64
) (
  input  sel_op_e              op,
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output logic [OUT_W-1:0]     res,
  output logic                 invalid
);

  localparam int W = 1 + EXP_W + MAN_W;

  function automatic logic f_is_nan(input logic [W-1:0] v);
    return (v[W-2:MAN_W] == '1) && (v[MAN_W-1:0] != '0);
  endfunction

  function automatic logic f_is_snan(input logic [W-1:0] v);
    return f_is_nan(v) && !v[MAN_W-1];
  endfunction

  logic a_nan, b_nan, a_snan, b_snan;
  logic lt_k [2];
  logic le_k [2];

  assign a_nan  = f_is_nan(a);
  assign b_nan  = f_is_nan(b);
  assign a_snan = f_is_snan(a);
  assign b_snan = f_is_snan(b);

  // k = 0: signed order, k = 1: magnitude order (sign forced to zero)
  for (genvar k = 0; k < 2; k++) begin : g_ord
    logic [W-1:0] xa;
    logic [W-1:0] xb;
    assign xa = (k == 1) ? {1'b0, a[W-2:0]} : a;
    assign xb = (k == 1) ? {1'b0, b[W-2:0]} : b;
    fsel_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ord (
      .x    (xa),
      .y    (xb),
      .lt_xy(lt_k[k]),
      .le_yx(le_k[k])
    );
  end

  logic use_mag, want_max, ord_hit, keep_a;
  logic [W-1:0] pick;

  assign use_mag  = op[1];
  assign want_max = op[0];
  assign ord_hit  = want_max ? le_k[use_mag] : lt_k[use_mag];
  assign keep_a   = b_nan || ord_hit;
  assign pick     = keep_a ? a : b;
  assign res      = OUT_W'(pick);
  assign invalid  = a_snan || b_snan;

  always_comb begin
    AST_NAN_UNORDERED: assert (!(a_nan || b_nan) || !(lt_k[0] || le_k[0] || lt_k[1] || le_k[1])); // R6
  end

endmodule

// File: rtl/fsel_unit.sv
module fsel_unit
  import fsel_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int INSTR_W = 32,
  parameter int SP_EXP  = 8,
  parameter int SP_MAN  = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_MAN  = 52
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_in,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  op_a,
  input  logic [DATA_W-1:0]  op_b,
  output logic               valid_out,
  output logic [DATA_W-1:0]  result,
  output logic [FLAG_W-1:0]  exc_flags,
  output logic               illegal
);

  localparam int SP_W = 1 + SP_EXP + SP_MAN;

  sel_cmd_t cmd;
  logic     unused_instr_hi;

  assign unused_instr_hi = ^instr[INSTR_W-1:MATCH_W];

  fsel_decode u_dec (
    .field(instr[MATCH_W-1:0]),
    .cmd  (cmd)
  );

  logic [DATA_W-1:0] lane_res [2];
  logic              lane_inv [2];

  // p = 0: single precision lane, p = 1: double precision lane
  for (genvar p = 0; p < 2; p++) begin : g_lane
    localparam int EW = (p == 0) ? SP_EXP : DP_EXP;
    localparam int MW = (p == 0) ? SP_MAN : DP_MAN;
    localparam int LW = 1 + EW + MW;
    fsel_lane #(.EXP_W(EW), .MAN_W(MW), .OUT_W(DATA_W)) u_lane (
      .op     (cmd.op),
      .a      (op_a[LW-1:0]),
      .b      (op_b[LW-1:0]),
      .res    (lane_res[p]),
      .invalid(lane_inv[p])
    );
  end

  logic [DATA_W-1:0] sel_res;
  logic              sel_inv;
  logic              accept;

  assign sel_res = cmd.dbl ? lane_res[1] : lane_res[0];
  assign sel_inv = cmd.dbl ? lane_inv[1] : lane_inv[0];
  assign accept  = valid_in && cmd.legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      result    <= '0;
      exc_flags <= '0;
      illegal   <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        illegal   <= !cmd.legal;
        result    <= cmd.legal ? sel_res : '0;
        exc_flags <= '0;
        if (cmd.legal) exc_flags[FLAG_INV] <= sel_inv;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> (!valid_out && $stable(result) && $stable(exc_flags) && $stable(illegal))); // R1
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && illegal) |-> (result == '0 && exc_flags == '0)); // R2
  AST_LOW_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    exc_flags[FLAG_INV-1:0] == '0); // R7
  AST_DBL_IS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd.dbl) |=> (result == $past(op_a) || result == $past(op_b))); // R3
  AST_SGL_IS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd.dbl) |=> (result[DATA_W-1:SP_W] == '0 &&
      (result[SP_W-1:0] == $past(op_a[SP_W-1:0]) || result[SP_W-1:0] == $past(op_b[SP_W-1:0])))); // R8

endmodule

// File: tb/fsel_unit_test.sv
module fsel_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        valid_out;
  logic [63:0] result;
  logic [4:0]  exc_flags;
  logic        illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fsel_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .instr(instr),
    .op_a(op_a), .op_b(op_b), .valid_out(valid_out), .result(result),
    .exc_flags(exc_flags), .illegal(illegal)
  );

  logic [63:0] sp_vals [13];
  logic [63:0] dp_vals [13];

  function automatic bit m_nan(logic [63:0] v, bit dp);
    if (dp) return (v[62:52] == 11'h7ff) && (v[51:0] != 0);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction

  function automatic bit m_snan(logic [63:0] v, bit dp);
    return m_nan(v, dp) && !(dp ? v[51] : v[22]);
  endfunction

  // signed rank: magnitude negated for negative values, both zeros rank 0
  function automatic logic signed [64:0] m_rank(logic [63:0] v, bit dp, bit mag);
    logic signed [64:0] m;
    bit s;
    m = dp ? {2'b0, v[62:0]} : {34'b0, v[30:0]};
    s = dp ? v[63] : v[31];
    if (s && !mag) return -m;
    return m;
  endfunction

  function automatic logic [63:0] m_expect(int op, bit dp, logic [63:0] a, logic [63:0] b);
    logic [63:0] ea, eb;
    bit na, nb, keep;
    logic signed [64:0] ra, rb;
    ea = dp ? a : {32'b0, a[31:0]};
    eb = dp ? b : {32'b0, b[31:0]};
    na = m_nan(ea, dp);
    nb = m_nan(eb, dp);
    ra = m_rank(ea, dp, op >= 2);
    rb = m_rank(eb, dp, op >= 2);
    if (op[0]) keep = nb || (!na && rb <= ra);
    else       keep = nb || (!na && ra < rb);
    return keep ? ea : eb;
  endfunction

  function automatic string m_tag(int op, bit dp, logic [63:0] a, logic [63:0] b);
    bit za, zb;
    za = dp ? (a[62:0] == 0) : (a[30:0] == 0);
    zb = dp ? (b[62:0] == 0) : (b[30:0] == 0);
    if (m_nan(a, dp) || m_nan(b, dp)) return "R6";
    if (za && zb) return "R9";
    if (op >= 2) return "R5";
    if (op == 1) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(int op, bit dp, logic [14:0] hi);
    return {hi, 5'(24 + op), 4'b0, dp, 7'h53};
  endfunction

  task automatic apply(logic [31:0] w, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    valid_in = 1'b1; instr = w; op_a = a; op_b = b;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1: watchdog expired, actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    sp_vals = '{64'h0, 64'h80000000, 64'h3f800000, 64'hbf800000, 64'h40200000,
                64'hc0400000, 64'h7f800000, 64'hff800000, 64'h7fc00000,
                64'h7f800001, 64'hffc00001, 64'h00000001, 64'hbf000000};
    dp_vals = '{64'h0, 64'h8000000000000000, 64'h3ff0000000000000, 64'hbff0000000000000,
                64'h4004000000000000, 64'hc008000000000000, 64'h7ff0000000000000,
                64'hfff0000000000000, 64'h7ff8000000000000, 64'h7ff0000000000001,
                64'hfff8000000000001, 64'h0000000000000001, 64'hbfe0000000000000};

    repeat (3) @(negedge clk);
    check("R1", {60'b0, valid_out, illegal, 2'b0}, 64'h0);
    check("R1", result, 64'h0);
    check("R1", {59'b0, exc_flags}, 64'h0);
    rst_n = 1'b1;

    // full sweep: both precisions, four selections, every operand pair
    for (int dpi = 0; dpi < 2; dpi++) begin
      for (int op = 0; op < 4; op++) begin
        for (int i = 0; i < 13; i++) begin
          for (int j = 0; j < 13; j++) begin
            logic [63:0] a, b, exp;
            bit dp;
            dp = (dpi == 1);
            a = dp ? dp_vals[i] : {32'hdead0000 | 32'(i), sp_vals[i][31:0]};
            b = dp ? dp_vals[j] : {32'hbeef0000 | 32'(j), sp_vals[j][31:0]};
            apply(mk_instr(op, dp, 15'(i * 7 + j)), a, b);
            exp = m_expect(op, dp, a, b);
            check("R1", {63'b0, valid_out}, 64'h1);
            check("R2", {63'b0, illegal}, 64'h0);
            check(m_tag(op, dp, a, b), result, exp);
            check("R7", {59'b0, exc_flags},
                  {59'b0, m_snan(a, dp) || m_snan(b, dp), 4'b0});
            if (!dp) check("R8", {32'b0, result[63:32]}, 64'h0);
          end
        end
      end
    end

    // hold: no strobe, operands change, outputs keep their values
    begin
      logic [63:0] prev;
      apply(mk_instr(1, 1'b1, 15'h0), dp_vals[2], dp_vals[4]);
      prev = result;
      check("R3", prev, dp_vals[4]);
      op_a = dp_vals[6]; op_b = dp_vals[9];
      @(negedge clk);
      check("R1", {63'b0, valid_out}, 64'h0);
      check("R1", result, prev);
    end

    // illegal words, even with signalling NaN operands
    begin
      logic [31:0] bad [5];
      bad = '{32'h00018057, 32'h00017053, 32'h00018153, 32'h0001c053, 32'h00010053};
      for (int k = 0; k < 5; k++) begin
        apply(bad[k], dp_vals[9], 64'h7f800001);
        check("R2", {63'b0, illegal}, 64'h1);
        check("R2", result, 64'h0);
        check("R2", {59'b0, exc_flags}, 64'h0);
      end
    end

    // legal word with upper bits set after an illegal one
    apply(mk_instr(0, 1'b0, 15'h7fff), 64'h40200000, 64'hbf800000);
    check("R2", {63'b0, illegal}, 64'h0);
    check("R4", result, 64'hbf800000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule